// File: doc/BRIEF.md
# SPI FIFO DMA Request Generator

This block sits beside the transmit and receive FIFOs of an SPI controller and tells a DMA engine when each FIFO can take part in a transfer. Each FIFO reports its occupancy as a count. The block captures both counts in a register every clock. From those captured counts it drives two level-sensitive requests per direction. A single request means at least one word can move. A burst request means the FIFO has crossed a programmable fractional threshold.

Software sets up the block through a small register port. A control register holds one enable bit per direction. A level-select register holds one 3-bit threshold code per direction, and the two directions use different threshold meanings. A status register holds two raw completion flags, one per direction. The DMA engine sets a flag with a one-cycle done pulse. Software clears a flag by writing a one to its bit.

No data flows through this block, so it has no valid/ready interface and no back-pressure. Each request stays high while its condition holds, and the DMA engine acts on it whenever it is ready.

Top module: `spi_dma_req_gen`

## Requirements
- R1: After reset, the control register reads 0 and the level-select register reads 0x0000_0101, which means both threshold codes are 1 (half). The status register reads 0 and all four requests are low.
- R2: With RX enabled, the RX single request is high exactly when the captured RX count is at least 1.
- R3: With RX enabled, the RX burst request is high when the captured RX count is at or above the RX threshold. The RX threshold code sits in bits [10:8] of the level-select register (address 1). Codes 0, 1, 2 and 3 give thresholds of 2, 4, 6 and 8 entries. Any other code gives 4.
- R4: With TX enabled, the TX single request is high exactly when the captured TX count is below the depth of 8.
- R5: With TX enabled, the TX burst request is high when the captured TX count is at or below the TX threshold. The TX threshold code sits in bits [2:0] of the level-select register. Codes 0, 1, 2 and 3 give thresholds of 2, 4, 6 and 0 entries. Any other code gives 4.
- R6: Control register (address 0) bit 0 enables RX and bit 8 enables TX. While an enable bit is clear, both requests of that direction stay low.
- R7: A TX done pulse sets status bit 8 and an RX done pulse sets status bit 7 on the next clock edge. The status register is at address 2.
- R8: Writing 1 to a status bit at address 2 clears that bit. Writing 0 to a status bit leaves it unchanged.
- R9: If a done pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R10: The requests follow the FIFO counts captured at the previous clock edge. A count change becomes visible on the requests only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 level select, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| tx_fill | input | 4 | TX FIFO occupancy count |
| rx_fill | input | 4 | RX FIFO occupancy count |
| tx_dma_done | input | 1 | TX DMA completion pulse |
| rx_dma_done | input | 1 | RX DMA completion pulse |
| tx_single_req | output | 1 | TX single-transfer request |
| tx_burst_req | output | 1 | TX burst request |
| rx_single_req | output | 1 | RX single-transfer request |
| rx_burst_req | output | 1 | RX burst request |
| tx_done_raw | output | 1 | Raw TX completion flag (status bit 8) |
| rx_done_raw | output | 1 | Raw RX completion flag (status bit 7) |

## Verification
A completion pulse from the DMA engine can arrive in the same cycle as a software write that clears the same status flag. The bench creates this collision by raising a done pulse while it writes a one to that flag's bit. It then reads the status register after the edge and requires the flag to be set. A second collision clears the TX flag while the RX flag is being set. The bench then checks that only the TX bit dropped.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_LEVEL = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;

  localparam int unsigned BIT_RX_EN   = 0;
  localparam int unsigned BIT_TX_EN   = 8;
  localparam int unsigned BIT_RX_DONE = 7;
  localparam int unsigned BIT_TX_DONE = 8;
  localparam int unsigned TX_SEL_LSB  = 0;
  localparam int unsigned RX_SEL_LSB  = 8;
  localparam int unsigned SEL_W       = 3;

  typedef enum logic [SEL_W-1:0] {
    LVL_QTR  = 3'd0,
    LVL_HALF = 3'd1,
    LVL_3QTR = 3'd2,
    LVL_END  = 3'd3
  } lvl_code_e;

  // Threshold in entries. The END code means full for RX and empty for TX.
  function automatic int unsigned lvl_entries(input logic [SEL_W-1:0] code,
                                              input int unsigned depth,
                                              input bit is_tx);
    case (code)
      LVL_QTR:  return depth / 4;
      LVL_HALF: return depth / 2;
      LVL_3QTR: return (3 * depth) / 4;
      LVL_END:  return is_tx ? 0 : depth;
      default:  return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/spi_dma_regs.sv
module spi_dma_regs
  import spi_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  output logic              rx_en,
  output logic              tx_en,
  output logic [SEL_W-1:0]  rx_sel,
  output logic [SEL_W-1:0]  tx_sel,
  output logic              tx_sts,
  output logic              rx_sts
);

  logic wr_ctrl, wr_level, wr_stat;
  logic clr_tx, clr_rx;

  assign wr_ctrl  = wr && (addr == A_CTRL);
  assign wr_level = wr && (addr == A_LEVEL);
  assign wr_stat  = wr && (addr == A_STAT);
  assign clr_tx   = wr_stat && wdata[BIT_TX_DONE];
  assign clr_rx   = wr_stat && wdata[BIT_RX_DONE];

  // Write data bits that no register uses.
  logic unused_wdata;
  assign unused_wdata = ^{wdata[REG_W-1:RX_SEL_LSB+SEL_W], wdata[6:TX_SEL_LSB+SEL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
    end else if (wr_ctrl) begin
      rx_en <= wdata[BIT_RX_EN];
      tx_en <= wdata[BIT_TX_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sel <= LVL_HALF;
      tx_sel <= LVL_HALF;
    end else if (wr_level) begin
      rx_sel <= wdata[RX_SEL_LSB +: SEL_W];
      tx_sel <= wdata[TX_SEL_LSB +: SEL_W];
    end
  end

  // A done pulse takes priority over a clearing write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sts <= 1'b0;
      rx_sts <= 1'b0;
    end else begin
      tx_sts <= tx_done_i | (tx_sts & ~clr_tx);
      rx_sts <= rx_done_i | (rx_sts & ~clr_rx);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[BIT_RX_EN] = rx_en;
        rdata[BIT_TX_EN] = tx_en;
      end
      A_LEVEL: begin
        rdata[RX_SEL_LSB +: SEL_W] = rx_sel;
        rdata[TX_SEL_LSB +: SEL_W] = tx_sel;
      end
      A_STAT: begin
        rdata[BIT_TX_DONE] = tx_sts;
        rdata[BIT_RX_DONE] = rx_sts;
      end
      default: rdata = '0;
    endcase
  end

  p_tx_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_i |=> tx_sts);
  p_rx_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i |=> rx_sts);
  p_tx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tx && !tx_done_i) |=> !tx_sts);
  p_rx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rx && !rx_done_i) |=> !rx_sts);
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_tx && !tx_done_i) |=> $stable(tx_sts));
  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tx && tx_done_i) |=> tx_sts);

endmodule

// File: rtl/spi_dma_chan.sv
module spi_dma_chan
  import spi_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter bit          IS_TX = 1'b0,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [CW-1:0]    fill,
  output logic             single_req,
  output logic             burst_req
);

  logic [CW-1:0] thr;
  assign thr = CW'(lvl_entries(sel, DEPTH, IS_TX));

  generate
    if (IS_TX) begin : g_tx
      // TX: a free slot permits a single move; draining to the threshold permits a burst.
      assign single_req = en && (fill < CW'(DEPTH));
      assign burst_req  = en && (fill <= thr);

      p_burst_needs_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |-> single_req);
    end else begin : g_rx
      // RX: any entry permits a single move; filling to the threshold permits a burst.
      assign single_req = en && (fill != '0);
      assign burst_req  = en && (fill >= thr);

      p_burst_needs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |-> single_req);
    end
  endgenerate

endmodule

// File: rtl/spi_dma_req_gen.sv
module spi_dma_req_gen
  import spi_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [CW-1:0]     tx_fill,
  input  logic [CW-1:0]     rx_fill,
  input  logic              tx_dma_done,
  input  logic              rx_dma_done,
  output logic              tx_single_req,
  output logic              tx_burst_req,
  output logic              rx_single_req,
  output logic              rx_burst_req,
  output logic              tx_done_raw,
  output logic              rx_done_raw
);

  logic             rx_en_w, tx_en_w;
  logic [SEL_W-1:0] rx_sel_w, tx_sel_w;
  logic [CW-1:0]    tx_fill_q, rx_fill_q;

  spi_dma_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .tx_done_i (tx_dma_done),
    .rx_done_i (rx_dma_done),
    .rx_en     (rx_en_w),
    .tx_en     (tx_en_w),
    .rx_sel    (rx_sel_w),
    .tx_sel    (tx_sel_w),
    .tx_sts    (tx_done_raw),
    .rx_sts    (rx_done_raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_fill_q <= CW'(DEPTH);
      rx_fill_q <= '0;
    end else begin
      tx_fill_q <= tx_fill;
      rx_fill_q <= rx_fill;
    end
  end

  spi_dma_chan #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (tx_en_w),
    .sel        (tx_sel_w),
    .fill       (tx_fill_q),
    .single_req (tx_single_req),
    .burst_req  (tx_burst_req)
  );

  spi_dma_chan #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (rx_en_w),
    .sel        (rx_sel_w),
    .fill       (rx_fill_q),
    .single_req (rx_single_req),
    .burst_req  (rx_burst_req)
  );

  p_rx_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_w |-> (!rx_single_req && !rx_burst_req));
  p_tx_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_w |-> (!tx_single_req && !tx_burst_req));
  p_rx_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_w && $past(rst_n)) |-> (rx_single_req == ($past(rx_fill) != '0)));
  p_tx_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_w && $past(rst_n)) |-> (tx_single_req == ($past(tx_fill) < CW'(DEPTH))));

endmodule

// File: tb/spi_dma_req_gen_test.sv
module spi_dma_req_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  tx_fill = 4'd0;
  logic [3:0]  rx_fill = 4'd0;
  logic        tx_dma_done = 1'b0;
  logic        rx_dma_done = 1'b0;
  logic        tx_single_req, tx_burst_req, rx_single_req, rx_burst_req;
  logic        tx_done_raw, rx_done_raw;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  spi_dma_req_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_fill(tx_fill),
    .rx_fill(rx_fill), .tx_dma_done(tx_dma_done), .rx_dma_done(rx_dma_done),
    .tx_single_req(tx_single_req), .tx_burst_req(tx_burst_req),
    .rx_single_req(rx_single_req), .rx_burst_req(rx_burst_req),
    .tx_done_raw(tx_done_raw), .rx_done_raw(rx_done_raw)
  );

  // {rx_sel, tx_sel, rx_count, tx_count, expected {rx_single, rx_burst, tx_single, tx_burst}}
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {3'd1, 3'd1, 4'd0, 4'd8, 4'b0000},
    {3'd1, 3'd1, 4'd4, 4'd4, 4'b1111},
    {3'd1, 3'd1, 4'd3, 4'd5, 4'b1010},
    {3'd0, 3'd0, 4'd2, 4'd2, 4'b1111},
    {3'd0, 3'd0, 4'd1, 4'd3, 4'b1010},
    {3'd2, 3'd2, 4'd6, 4'd6, 4'b1111},
    {3'd2, 3'd2, 4'd5, 4'd7, 4'b1010},
    {3'd3, 3'd3, 4'd8, 4'd0, 4'b1111},
    {3'd3, 3'd3, 4'd7, 4'd1, 4'b1010},
    {3'd5, 3'd6, 4'd4, 4'd4, 4'b1111},
    {3'd7, 3'd4, 4'd3, 4'd5, 4'b1010},
    {3'd0, 3'd3, 4'd8, 4'd8, 4'b1100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge, after the write lands.
  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [3:0] reqs();
    return {rx_single_req, rx_burst_req, tx_single_req, tx_burst_req};
  endfunction

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd0, rd); chk("R1 ctrl", rd, 32'h0);
    reg_read(2'd1, rd); chk("R1 level", rd, 32'h0000_0101);
    reg_read(2'd2, rd); chk("R1 status", rd, 32'h0);
    chk("R1 requests", 32'(reqs()), 32'h0);

    // R6: counts that would request, but both directions disabled
    rx_fill = 4'd8; tx_fill = 4'd0;
    @(negedge clk);
    chk("R6 disabled", 32'(reqs()), 32'h0);
    reg_write(2'd0, 32'h0000_0001);
    chk("R6 rx only", 32'(reqs()), 32'(4'b1100));
    reg_write(2'd0, 32'h0000_0100);
    chk("R6 tx only", 32'(reqs()), 32'(4'b0011));
    reg_write(2'd0, 32'h0000_0101);

    // R2 R3 R4 R5 table
    for (int i = 0; i < NV; i++) begin
      reg_write(2'd1, (32'(VEC[i][17:15]) << 8) | 32'(VEC[i][14:12]));
      rx_fill = VEC[i][11:8];
      tx_fill = VEC[i][7:4];
      @(negedge clk);
      chk($sformatf("R2 rx single v%0d", i), 32'(rx_single_req), 32'(VEC[i][3]));
      chk($sformatf("R3 rx burst v%0d", i),  32'(rx_burst_req),  32'(VEC[i][2]));
      chk($sformatf("R4 tx single v%0d", i), 32'(tx_single_req), 32'(VEC[i][1]));
      chk($sformatf("R5 tx burst v%0d", i),  32'(tx_burst_req),  32'(VEC[i][0]));
    end

    // R10 one-edge latency
    reg_write(2'd1, 32'h0000_0101);
    rx_fill = 4'd0; tx_fill = 4'd8;
    @(negedge clk);
    chk("R10 settled", 32'(reqs()), 32'h0);
    rx_fill = 4'd5; tx_fill = 4'd3;
    #1 chk("R10 before edge", 32'(reqs()), 32'h0);
    @(negedge clk);
    chk("R10 after edge", 32'(reqs()), 32'(4'b1111));

    // R7 done pulses
    tx_dma_done = 1'b1;
    @(negedge clk);
    tx_dma_done = 1'b0;
    reg_read(2'd2, rd); chk("R7 tx done", rd, 32'h0000_0100);
    chk("R7 tx raw pin", 32'(tx_done_raw), 32'h1);
    rx_dma_done = 1'b1;
    @(negedge clk);
    rx_dma_done = 1'b0;
    reg_read(2'd2, rd); chk("R7 both done", rd, 32'h0000_0180);

    // R8 writing zero does nothing; writing one clears only that bit
    reg_write(2'd2, 32'h0000_0000);
    reg_read(2'd2, rd); chk("R8 zero write", rd, 32'h0000_0180);
    reg_write(2'd2, 32'h0000_0100);
    reg_read(2'd2, rd); chk("R8 clear tx", rd, 32'h0000_0080);
    reg_write(2'd2, 32'h0000_0080);
    reg_read(2'd2, rd); chk("R8 clear rx", rd, 32'h0);

    // R9 set beats clear in the same cycle
    tx_dma_done = 1'b1;
    reg_write(2'd2, 32'h0000_0100);
    tx_dma_done = 1'b0;
    reg_read(2'd2, rd); chk("R9 tx collide", rd, 32'h0000_0100);
    rx_dma_done = 1'b1;
    reg_write(2'd2, 32'h0000_0180);
    rx_dma_done = 1'b0;
    reg_read(2'd2, rd); chk("R9 rx collide, tx cleared", rd, 32'h0000_0080);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule